// File: doc/BRIEF.md
# E1 Signaling Timeslot Alarm Detector

This block watches the signaling timeslot (timeslot 16) of an E1 receive stream whose frame and multiframe alignment have already been found upstream. Each frame the framer hands over the timeslot 16 octet together with the frame's position (0 to 15) inside the signaling multiframe and a flag saying multiframe alignment is held. The block judges each complete multiframe and drives three alarm levels: signaling all ones, signaling all zeros, and distant multiframe alarm.

The octet input is a valid/ready stream. The detector has no internal queue and never stalls, so `ts_ready` stays high outside reset. An octet counts only in a cycle where both `ts_valid` and `ts_ready` are high. The frame number and the alignment flag are sampled with the octet. The all-ones and all-zeros alarms are judged on totals over a full run of frames 0 to 15 taken in order. The distant alarm is judged on a single bit of the frame 0 octet, with a two-multiframe hysteresis in each direction. Bits are numbered in the line convention: bit 1 is the octet MSB, so bit 6 is `ts_data[2]`.

Top module: `e1_sig_alarm`

## Requirements
- R1: `ts_ready` is high in every cycle after reset. An octet is taken in each cycle where `ts_valid` is high.
- R2: The signaling-all-ones alarm sets when a complete multiframe holds fewer than three zero bits across its 16 octets. It updates one cycle after the frame 15 octet is taken.
- R3: The signaling-all-ones alarm clears when a complete multiframe holds three or more zero bits. It updates on the same cycle as in R2.
- R4: The signaling-all-zeros alarm sets when all 128 bits of a complete multiframe are zero. It updates one cycle after the frame 15 octet is taken.
- R5: The signaling-all-zeros alarm clears when a complete multiframe holds at least one bit set to one.
- R6: The distant multiframe alarm sets when bit 6 (`ts_data[2]`) of the frame 0 octet is one in two consecutive aligned multiframes. It updates one cycle after that frame 0 octet is taken.
- R7: The distant multiframe alarm clears when bit 6 of the frame 0 octet is zero in two consecutive aligned multiframes.
- R8: A single frame 0 octet whose bit 6 differs from the current distant alarm level leaves that alarm unchanged.
- R9: A multiframe is complete only if frames 0 through 15 arrive in order with alignment held. If any frame is missing or out of order, the all-ones and all-zeros alarms keep their values at its end.
- R10: Octets taken while `mf_locked` is low are ignored, and all three alarms hold. Such an octet also breaks the consecutive-multiframe run used in R6 and R7.
- R11: After reset all three alarms are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Timeslot 16 octet present |
| ts_ready | output | 1 | Octet accepted; high outside reset |
| ts_data | input | 8 | Timeslot 16 octet, bit 1 at the MSB |
| frame_num | input | 4 | Frame index within the multiframe, 0 to 15 |
| mf_locked | input | 1 | Multiframe alignment held |
| alm_sig_ones | output | 1 | Signaling all-ones alarm |
| alm_sig_zeros | output | 1 | Signaling all-zeros alarm |
| alm_dist_mf | output | 1 | Distant multiframe alarm |

## Verification
The all-ones and all-zeros alarms change only at the clock edge that takes a frame 15 octet. The distant alarm changes only at the edge that takes a frame 0 octet. All three are therefore settled one cycle after that octet. The driver records the expected levels right after the edge that takes each multiframe's last octet. The monitor compares them at the next falling edge, which is after both update points and before any further octet can be taken. Stimulus includes a multiframe with a missing frame and one sent without alignment. For both, the expected value is the unchanged prior level, which shows that no update took place.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  typedef struct packed {
    logic sig_ones;
    logic sig_zeros;
    logic dist_mf;
  } e1sa_alarms_t;
endpackage

// File: rtl/e1sa_window.sv
module e1sa_window #(
  parameter int MF_LEN = 16,
  parameter int FN_W   = $clog2(MF_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            locked,
  input  logic [FN_W-1:0] fn,
  output logic            mf_first,
  output logic            mf_step,
  output logic            mf_last
);
  logic            in_win;
  logic [FN_W-1:0] exp_fn;

  // frame 0 always opens a fresh window; later frames must follow in order
  assign mf_first = acc && locked && (fn == '0);
  assign mf_step  = acc && locked && in_win && (fn != '0) && (fn == exp_fn);
  assign mf_last  = mf_step && (fn == FN_W'(MF_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_win <= 1'b0;
      exp_fn <= '0;
    end else if (!locked) begin
      in_win <= 1'b0;
    end else if (acc) begin
      if (mf_first) begin
        in_win <= 1'b1;
        exp_fn <= FN_W'(1);
      end else if (mf_step) begin
        exp_fn <= exp_fn + FN_W'(1);
        if (mf_last) in_win <= 1'b0;
      end else begin
        in_win <= 1'b0; // out-of-order frame breaks the window (R9)
      end
    end
  end

  a_r9_first_opens: assert property (@(posedge clk) disable iff (!rst_n)
    mf_first |=> in_win);
  a_r10_unlock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !in_win);
endmodule

// File: rtl/e1sa_zero_acc.sv
module e1sa_zero_acc #(
  parameter int OCT_W = 8,
  parameter int LIMIT = 3,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first,
  input  logic             step,
  input  logic [OCT_W-1:0] data,
  output logic [CW-1:0]    tot_zeros,
  output logic             tot_any
);
  logic [CW-1:0] zcnt;
  logic          any_r;
  int            oct_zeros;
  int            sum;

  always_comb begin
    oct_zeros = 0;
    for (int i = 0; i < OCT_W; i++) begin
      if (!data[i]) oct_zeros = oct_zeros + 1;
    end
    sum = (first ? 0 : int'(zcnt)) + oct_zeros;
    if (sum > LIMIT) sum = LIMIT;     // saturate the running count
    tot_zeros = CW'(sum);
    tot_any   = (first ? 1'b0 : any_r) | (|data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zcnt  <= '0;
      any_r <= 1'b0;
    end else if (first || step) begin
      zcnt  <= tot_zeros;
      any_r <= tot_any;
    end
  end

  a_r2_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    int'(zcnt) <= LIMIT);
  a_r5_any_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !first && any_r) |=> any_r);
endmodule

// File: rtl/e1sa_run_hyst.sv
module e1sa_run_hyst #(
  parameter int RUN = 2,
  parameter int RW  = $clog2(RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_runs,
  input  logic sample,
  input  logic bit_in,
  output logic alarm
);
  logic [RW-1:0] hi_run, lo_run;
  logic [RW-1:0] hi_nxt, lo_nxt;

  always_comb begin
    hi_nxt = hi_run;
    lo_nxt = lo_run;
    if (sample) begin
      if (bit_in) begin
        hi_nxt = (hi_run == RW'(RUN)) ? hi_run : hi_run + RW'(1);
        lo_nxt = '0;
      end else begin
        lo_nxt = (lo_run == RW'(RUN)) ? lo_run : lo_run + RW'(1);
        hi_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      alarm  <= 1'b0;
    end else if (clr_runs) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= hi_nxt;
      lo_run <= lo_nxt;
      if (sample && bit_in && hi_nxt == RW'(RUN))       alarm <= 1'b1;
      else if (sample && !bit_in && lo_nxt == RW'(RUN)) alarm <= 1'b0;
    end
  end

  a_r6_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_runs && sample && bit_in && int'(hi_run) >= RUN - 1) |=> alarm);
  a_r7_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_runs && sample && !bit_in && int'(lo_run) >= RUN - 1) |=> !alarm);
  a_r8_no_sample_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(alarm));
endmodule

// File: rtl/e1_sig_alarm.sv
module e1_sig_alarm
  import e1sa_pkg::*;
#(
  parameter int OCT_W      = 8,
  parameter int MF_LEN     = 16,
  parameter int ZERO_LIMIT = 3,
  parameter int DIST_BIT   = 2,
  parameter int DIST_RUN   = 2,
  localparam int FN_W      = $clog2(MF_LEN),
  localparam int CW        = $clog2(ZERO_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_valid,
  output logic             ts_ready,
  input  logic [OCT_W-1:0] ts_data,
  input  logic [FN_W-1:0]  frame_num,
  input  logic             mf_locked,
  output logic             alm_sig_ones,
  output logic             alm_sig_zeros,
  output logic             alm_dist_mf
);
  logic          acc;
  logic          mf_first, mf_step, mf_last;
  logic [CW-1:0] tot_zeros;
  logic          tot_any;
  e1sa_alarms_t  alm_q;

  assign ts_ready = 1'b1;             // never stalls (R1)
  assign acc      = ts_valid && ts_ready;

  e1sa_window #(.MF_LEN(MF_LEN), .FN_W(FN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .acc(acc), .locked(mf_locked), .fn(frame_num),
    .mf_first(mf_first), .mf_step(mf_step), .mf_last(mf_last)
  );

  e1sa_zero_acc #(.OCT_W(OCT_W), .LIMIT(ZERO_LIMIT), .CW(CW)) u_acc (
    .clk(clk), .rst_n(rst_n), .first(mf_first), .step(mf_step), .data(ts_data),
    .tot_zeros(tot_zeros), .tot_any(tot_any)
  );

  e1sa_run_hyst #(.RUN(DIST_RUN)) u_dist (
    .clk(clk), .rst_n(rst_n), .clr_runs(!mf_locked), .sample(mf_first),
    .bit_in(ts_data[DIST_BIT]), .alarm(alm_q.dist_mf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_q.sig_ones  <= 1'b0;
      alm_q.sig_zeros <= 1'b0;
    end else if (mf_last) begin
      alm_q.sig_ones  <= (int'(tot_zeros) < ZERO_LIMIT);
      alm_q.sig_zeros <= !tot_any;
    end
  end

  assign alm_sig_ones  = alm_q.sig_ones;
  assign alm_sig_zeros = alm_q.sig_zeros;
  assign alm_dist_mf   = alm_q.dist_mf;

  a_r2_ones_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_last && int'(tot_zeros) < ZERO_LIMIT) |=> alm_sig_ones);
  a_r3_ones_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_last && int'(tot_zeros) >= ZERO_LIMIT) |=> !alm_sig_ones);
  a_r4_zeros_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_last && !tot_any) |=> alm_sig_zeros);
  a_r5_zeros_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_last && tot_any) |=> !alm_sig_zeros);
  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_last |=> ($stable(alm_sig_ones) && $stable(alm_sig_zeros)));
  a_r10_unlocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_locked |=> ($stable(alm_sig_ones) && $stable(alm_sig_zeros) && $stable(alm_dist_mf)));
endmodule

// File: tb/e1_sig_alarm_tb.sv
module e1_sig_alarm_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ts_valid = 1'b0;
  logic       ts_ready;
  logic [7:0] ts_data = '0;
  logic [3:0] frame_num = '0;
  logic       mf_locked = 1'b0;
  logic       alm_sig_ones, alm_sig_zeros, alm_dist_mf;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic  e_ones;
    logic  e_zeros;
    logic  e_dist;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state kept from the requirements
  logic m_ones = 0, m_zeros = 0, m_dist = 0;
  int   hi_run = 0, lo_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_sig_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_ready(ts_ready),
    .ts_data(ts_data), .frame_num(frame_num), .mf_locked(mf_locked),
    .alm_sig_ones(alm_sig_ones), .alm_sig_zeros(alm_sig_zeros),
    .alm_dist_mf(alm_dist_mf)
  );

  task automatic check1(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // monitor: compare queued expectations one falling edge after they are due
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check1(alm_sig_ones,  it.e_ones,  {it.tag, " ones"});
      check1(alm_sig_zeros, it.e_zeros, {it.tag, " zeros"});
      check1(alm_dist_mf,   it.e_dist,  {it.tag, " dist"});
    end
  end

  task automatic put_octet(input logic [7:0] d, input logic [3:0] fn, input logic lk);
    @(negedge clk);
    ts_valid  = 1'b1;
    ts_data   = d;
    frame_num = fn;
    mf_locked = lk;
    @(posedge clk);
  endtask

  // one multiframe: frame 0 carries f0, frames 1..15 carry rest
  task automatic send_mf(input logic [7:0] f0, input logic [7:0] rest,
                         input logic lk, input logic broken, input string tag);
    int   zc;
    logic any1;
    exp_t it;
    for (int fn = 0; fn < 16; fn++) begin
      if (broken && fn == 8) continue;
      put_octet((fn == 0) ? f0 : rest, 4'(fn), lk);
    end
    if (lk) begin
      if (f0[2]) begin hi_run++; lo_run = 0; if (hi_run >= 2) m_dist = 1; end
      else       begin lo_run++; hi_run = 0; if (lo_run >= 2) m_dist = 0; end
      if (!broken) begin
        zc   = $countones(~f0) + 15 * $countones(~rest);
        any1 = (f0 != 8'h00) || (rest != 8'h00);
        m_ones  = (zc < 3);
        m_zeros = !any1;
      end
    end else begin
      hi_run = 0; lo_run = 0;
    end
    it.e_ones = m_ones; it.e_zeros = m_zeros; it.e_dist = m_dist; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    ts_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check1(alm_sig_ones,  1'b0, "R11 ones");
    check1(alm_sig_zeros, 1'b0, "R11 zeros");
    check1(alm_dist_mf,   1'b0, "R11 dist");
    check1(ts_ready,      1'b1, "R1 ready");

    send_mf(8'hFF, 8'hFF, 1, 0, "R2 no zeros");         // ones sets, dist run 1
    send_mf(8'hFF, 8'hFF, 1, 0, "R6 second bit6 one");  // dist sets
    send_mf(8'hFB, 8'hFF, 1, 0, "R8 single bit6 zero"); // 1 zero, dist holds
    send_mf(8'hF8, 8'hFF, 1, 0, "R3 R7 three zeros");   // ones clears, dist clears
    send_mf(8'h00, 8'h00, 1, 0, "R4 all zero");
    send_mf(8'h04, 8'h00, 1, 0, "R5 one bit set");
    send_mf(8'h00, 8'h00, 1, 1, "R9 missing frame");    // zeros alarm must hold
    send_mf(8'h04, 8'h00, 1, 0, "R8 bit6 run start");
    send_mf(8'h00, 8'h00, 0, 0, "R10 unlocked");        // everything holds
    send_mf(8'h04, 8'h00, 1, 0, "R10 run broken");      // dist stays low
    send_mf(8'h04, 8'h00, 1, 0, "R6 run complete");
    check1(ts_ready, 1'b1, "R1 ready after traffic");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule